// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream with two stages. A holding register captures the parallel bus on a capture strobe. A shift register of the same width takes a copy of the holding register while the active-low load control is asserted. It then moves one place per shift strobe. New serial data enters at stage 0, and the last stage drives the serial output. Because the two registers have separate strobes, the next word can be captured while the current one is still being shifted out.

The whole block runs on one system clock with a synchronous active-high reset. The capture and shift strobes are single-cycle pulses. The active-low load and clear controls are levels sampled on every clock. Clear takes priority over load, and load takes priority over shifting. When load and clear are both asserted, clear wins and a one-cycle error pulse is raised. A capture strobe in the same cycle as a load passes the fresh bus value straight into the shift register.

Top module: `dbuf_piso`

## Requirements
- R1: After reset, `ser_out` and `conflict_err` are 0 and both registers hold all zeros, so a load followed by shifting with no capture yields only zeros.
- R2: On a cycle with `cap_stb` high, the holding register takes `par_in` whatever the levels of `load_n` and `clr_n`. Without `cap_stb` it keeps its value.
- R3: With `load_n` low and `clr_n` high, the shift register copies the holding register (bit i to stage i) on each clock, and `shift_stb` and `ser_in` have no effect.
- R4: With `clr_n` low and `load_n` high, the shift register becomes all zeros on the next clock, and `shift_stb` and `ser_in` have no effect.
- R5: With both controls high and `shift_stb` high, stage n takes stage n-1 and stage 0 takes `ser_in`. After 8 shifts in which bit 7-k of a word was fed at step k, the register holds that word.
- R6: `ser_out` is the last stage (stage 7). After a load it shows bit 7 of the word, and after k shifts it shows bit 7-k.
- R7: With `load_n` and `clr_n` both low, clear wins and the shift register is all zeros. It stays zero after both are released.
- R8: `conflict_err` is high for exactly one cycle, in the cycle after the first clock on which load and clear are both sampled low. It stays low while the conflict continues.
- R9: When `cap_stb` and a load (`load_n` low, `clr_n` high) fall in the same cycle, the shift register takes the current `par_in`, not the older held word.
- R10: With both controls high and no `shift_stb`, the shift register keeps its contents and `ser_in` is ignored.
- R11: A capture while a word is shifting out leaves the shifting word undisturbed, and the captured word comes out after the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | One-cycle strobe that captures `par_in` into the holding register |
| par_in | input | 8 | Parallel data bus |
| load_n | input | 1 | Active-low level: copy the holding register into the shift register |
| clr_n | input | 1 | Active-low level: clear the shift register |
| shift_stb | input | 1 | One-cycle strobe that advances the shift register |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data from the last stage |
| conflict_err | output | 1 | One-cycle pulse when load and clear first overlap |

## Verification
On every cycle, the embedded assertions check the clock-to-clock effect of each control. They check that clear zeroes the register, that load copies the selected source, that a shift moves `ser_in` into stage 0 and keeps the register's upper bits in step, that an idle cycle holds, that the holding register captures only on its strobe, and that the error flag is a single pulse caused by a real overlap. The directed scenarios show the end-to-end behaviour that no single-cycle property covers. These are the bit order seen at `ser_out` over whole words, the double-buffered capture during a shift, the flow-through of a simultaneous capture and load, and the zero contents left after a conflict is released.

// File: rtl/dbuf_piso_pkg.sv
package dbuf_piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } shop_e;
endpackage

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
  import dbuf_piso_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_n,
  input  logic  clr_n,
  input  logic  shift_stb,
  output shop_e op,
  output logic  conflict_err
);
  logic conflict;
  logic conflict_q;

  assign conflict = !load_n && !clr_n;

  // clear outranks load, load outranks shift
  always_comb begin
    if (!clr_n)         op = OP_CLEAR;
    else if (!load_n)   op = OP_LOAD;
    else if (shift_stb) op = OP_SHIFT;
    else                op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict_q   <= 1'b0;
      conflict_err <= 1'b0;
    end else begin
      conflict_q   <= conflict;
      conflict_err <= conflict && !conflict_q;
    end
  end

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    conflict_err |=> !conflict_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    conflict_err |-> $past(!load_n && !clr_n));
endmodule

// File: rtl/dbuf_hold_reg.sv
module dbuf_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (cap_stb) q <= d;
  end

  p_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> q == $past(d));

  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(q));
endmodule

// File: rtl/dbuf_shift_core.sv
module dbuf_shift_core
  import dbuf_piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  shop_e        op,
  input  logic [W-1:0] load_src,
  input  logic         ser_in,
  output logic [W-1:0] stage
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic prev;
    if (i == 0) begin : g_head
      assign prev = ser_in;
    end else begin : g_link
      assign prev = stage[i-1];
    end
    always_comb begin
      unique case (op)
        OP_CLEAR: nxt[i] = 1'b0;
        OP_LOAD:  nxt[i] = load_src[i];
        OP_SHIFT: nxt[i] = prev;
        default:  nxt[i] = stage[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= nxt;
  end

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    op == OP_CLEAR |=> stage == '0);

  p_load_copy_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> stage == $past(load_src));

  p_shift_head_r5: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> stage[0] == $past(ser_in));

  p_shift_top_r5: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> stage[W-1] == $past(stage[W-2]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(stage));
endmodule

// File: rtl/dbuf_piso.sv
module dbuf_piso
  import dbuf_piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_stb,
  input  logic [W-1:0] par_in,
  input  logic         load_n,
  input  logic         clr_n,
  input  logic         shift_stb,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         conflict_err
);
  shop_e        op;
  logic [W-1:0] held;
  logic [W-1:0] load_src;
  logic [W-1:0] stage;

  dbuf_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .load_n       (load_n),
    .clr_n        (clr_n),
    .shift_stb    (shift_stb),
    .op           (op),
    .conflict_err (conflict_err)
  );

  dbuf_hold_reg #(.W(W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (cap_stb),
    .d       (par_in),
    .q       (held)
  );

  // same-cycle capture and load passes the bus straight through (R9)
  assign load_src = cap_stb ? par_in : held;

  dbuf_shift_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_src (load_src),
    .ser_in   (ser_in),
    .stage    (stage)
  );

  assign ser_out = stage[W-1];

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !load_n) |=> !ser_out);
endmodule

// File: tb/sim_dbuf_piso.sv
`timescale 1ns/1ps
module sim_dbuf_piso;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_stb = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         load_n = 1'b1;
  logic         clr_n = 1'b1;
  logic         shift_stb = 1'b0;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic         conflict_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbuf_piso #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .par_in(par_in),
    .load_n(load_n), .clr_n(clr_n), .shift_stb(shift_stb),
    .ser_in(ser_in), .ser_out(ser_out), .conflict_err(conflict_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected<=200000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the rising edge
  task automatic cyc(input logic cap, input logic [W-1:0] d, input logic ld_n,
                     input logic cl_n, input logic sh, input logic si);
    @(negedge clk);
    cap_stb = cap; par_in = d; load_n = ld_n; clr_n = cl_n;
    shift_stb = sh; ser_in = si;
    @(posedge clk);
    #1;
    cap_stb = 1'b0; shift_stb = 1'b0; load_n = 1'b1; clr_n = 1'b1;
  endtask

  task automatic capture(input logic [W-1:0] d);
    cyc(1'b1, d, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic load();
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // check exp MSB first while shifting in fill, MSB first
  task automatic unload(input string req, input logic [W-1:0] exp, input logic [W-1:0] fill);
    logic [W-1:0] got;
    got = '0;
    for (int k = 0; k < W; k++) begin
      got[W-1-k] = ser_out;
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b1, fill[W-1-k]);
    end
    chk(req, {24'h0, got}, {24'h0, exp});
  endtask

  task automatic t_reset();
    chk("R1 ser_out after reset", {31'h0, ser_out}, 32'h0);
    chk("R1 conflict_err after reset", {31'h0, conflict_err}, 32'h0);
    load();
    unload("R1 holding register zero after reset", 8'h00, 8'h00);
  endtask

  task automatic t_load_shift();
    capture(8'hA5);
    load();
    chk("R6 ser_out is bit 7 after load", {31'h0, ser_out}, 32'h1);
    unload("R6 R3 word A5 out MSB first", 8'hA5, 8'h3C);
    unload("R5 serial fill 3C lands in register", 8'h3C, 8'h00);
  endtask

  task automatic t_cap_during_shift();
    logic [W-1:0] got;
    capture(8'hC3);
    load();
    got = '0;
    for (int k = 0; k < W; k++) begin
      got[W-1-k] = ser_out;
      cyc(k == 3, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
    end
    chk("R11 shifting word C3 undisturbed by capture", {24'h0, got}, 32'hC3);
    load();
    unload("R11 R2 captured word 5A after next load", 8'h5A, 8'h00);
  endtask

  task automatic t_cap_ignores_ctrl();
    capture(8'h00);
    cyc(1'b1, 8'h96, 1'b1, 1'b0, 1'b0, 1'b0);
    load();
    unload("R2 capture during clear still stores 96", 8'h96, 8'h00);
  endtask

  task automatic t_load_ignores_shift();
    capture(8'h6B);
    load();
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R3 shift ignored during load", {31'h0, ser_out}, 32'h0);
    unload("R3 word 6B intact after load with shifts", 8'h6B, 8'h00);
  endtask

  task automatic t_clear();
    capture(8'hFF);
    load();
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 clear zeroes ser_out", {31'h0, ser_out}, 32'h0);
    chk("R4 no conflict flag on plain clear", {31'h0, conflict_err}, 32'h0);
    unload("R4 register zero after clear with shift", 8'h00, 8'h00);
  endtask

  task automatic t_conflict();
    capture(8'hFF);
    load();
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 conflict_err in cycle after first overlap", {31'h0, conflict_err}, 32'h1);
    chk("R7 clear wins in conflict", {31'h0, ser_out}, 32'h0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 conflict_err drops while overlap held", {31'h0, conflict_err}, 32'h0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 conflict_err stays low", {31'h0, conflict_err}, 32'h0);
    cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8 conflict_err low after release", {31'h0, conflict_err}, 32'h0);
    unload("R7 register zero after conflict release", 8'h00, 8'h00);
  endtask

  task automatic t_flowthrough();
    capture(8'h11);
    cyc(1'b1, 8'hE7, 1'b0, 1'b1, 1'b0, 1'b0);
    unload("R9 simultaneous capture and load passes E7", 8'hE7, 8'h00);
  endtask

  task automatic t_hold();
    capture(8'h81);
    load();
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, k[0]);
      chk("R10 idle keeps ser_out", {31'h0, ser_out}, 32'h1);
    end
    unload("R10 word 81 intact after idle cycles", 8'h81, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_load_shift();
    t_cap_during_shift();
    t_cap_ignores_ctrl();
    t_load_ignores_shift();
    t_clear();
    t_conflict();
    t_flowthrough();
    t_hold();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule